// File: doc/BRIEF.md
# Byte-Memory DMA Packing Engine

The engine moves whole words between on-chip memory and an external byte-wide memory without further help from the core. Software programs a format, a direction, an on-chip start address and a 22-bit external start address. The external address is made of an 8-bit page and a 14-bit offset. Writing a non-zero word count then launches the transfer. For each word the engine makes one, two or three byte accesses on the external bus. It packs the bytes into a 24-bit program word, a 16-bit data word or an 8-bit value inside a data word, or it unpacks a word into bytes, most significant byte first. It takes exactly one cycle of the internal memory port per word.

The external byte address counts up as one 22-bit value, so it runs from one page into the next. The word count is live: it drops by one as each word completes and can be read at any time. When it reaches zero the engine goes idle and emits a one-cycle completion interrupt. The address and count registers are not reloaded when a transfer ends, so a later transfer started by writing the count alone continues where the previous one stopped.

Top module: `bdma_engine`

## Requirements
- R1: Register select 0 holds the control fields: bit 3 halt, bit 2 direction, bits 1:0 format. Format 00 moves 24-bit words and format 01 moves 16-bit words. The first byte accessed is the most significant byte: bits 23:16, then 15:8, then 7:0 for 24-bit words, and bits 15:8, then 7:0 for 16-bit words.
- R2: Format 10 places a single byte in word bits 15:8, and format 11 places it in bits 7:0. On a load every other bit of the written word is zero.
- R3: The byte address is {page, offset}, loaded through select 3 (page, 8 bits) and select 2 (offset, 14 bits). It rises by one after each byte access, carries from the offset into the page, and wraps from all-ones to zero.
- R4: Writing a non-zero value through select 4 while idle raises busy on the next clock. Writing zero loads the count but starts nothing.
- R5: The count output drops by exactly one as each word completes and holds its value in between.
- R6: When the last word completes, busy falls, the count reads zero and the interrupt is high for exactly one cycle.
- R7: Direction 0 reads bytes and writes words to internal memory. Direction 1 reads words from internal memory and writes bytes.
- R8: Each word uses exactly one cycle of internal-memory request. A load performs its byte reads, then one write cycle. A store performs one read-request cycle, then one cycle in which the read data, returned the cycle after the request, is taken, then its byte writes.
- R9: Each byte access keeps its strobe high for 1 + W cycles. W is the wait input sampled in the first cycle of that access.
- R10: The halt output is high exactly while busy with the halt bit set.
- R11: Every register write made while busy is ignored. Page, offset, internal address, count and control continue unchanged.
- R12: The internal address (select 1) rises by one per word. The space output is 0 (program memory) for format 00 and 1 (data memory) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 control, 1 internal address, 2 offset, 3 page, 4 count) |
| cfg_wdata | input | 16 | Register write data |
| cnt_o | output | CNT_W | Live remaining word count |
| busy_o | output | 1 | Transfer in progress |
| halt_o | output | 1 | Request to stall the core |
| irq_o | output | 1 | One-cycle completion pulse |
| im_req_o | output | 1 | Internal memory request |
| im_we_o | output | 1 | Internal memory write (1) or read (0) |
| im_space_o | output | 1 | 0 program memory, 1 data memory |
| im_addr_o | output | IADDR_W | Internal word address |
| im_wdata_o | output | 24 | Word written to internal memory |
| im_rdata_i | input | 24 | Internal read data, valid the cycle after a read request |
| bm_rd_o | output | 1 | Byte read strobe |
| bm_wr_o | output | 1 | Byte write strobe |
| bm_addr_o | output | OFS_W+PAGE_W | Byte address {page, offset} |
| bm_wdata_o | output | 8 | Byte write data |
| bm_rdata_i | input | 8 | Byte read data, taken in the last cycle of a read access |
| bm_wait_i | input | WAIT_W | Wait cycles per byte access |

## Verification
The properties assume three things about the inputs. The register port is driven only by the bench. Byte read data is valid in the final cycle of each access. Internal read data follows its request by one cycle. The bench holds the wait input constant through each transfer, changes it only between transfers, and serves both memories from address-derived patterns. During one transfer it writes the page, offset and count registers, so the busy-time address and count properties see the writes they must ignore.

// File: rtl/bdma_pkg.sv
package bdma_pkg;

  localparam int BYTE_W  = 8;
  localparam int LANES   = 3;
  localparam int WORD_W  = BYTE_W * LANES;

  typedef enum logic [1:0] {
    FMT_PM24  = 2'b00,
    FMT_DM16  = 2'b01,
    FMT_DM8HI = 2'b10,
    FMT_DM8LO = 2'b11
  } fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYTE,
    ST_IMWR,
    ST_FETCH,
    ST_CAPT
  } st_e;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_IADDR = 3'd1;
  localparam logic [2:0] SEL_OFS   = 3'd2;
  localparam logic [2:0] SEL_PAGE  = 3'd3;
  localparam logic [2:0] SEL_COUNT = 3'd4;

  // index of the final byte of a word in the given format
  function automatic logic [1:0] last_idx(fmt_e f);
    case (f)
      FMT_PM24: return 2'd2;
      FMT_DM16: return 2'd1;
      default:  return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bdma_addr_ctr.sv
module bdma_addr_ctr #(
  parameter int OFS_W  = 14,
  parameter int PAGE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_ofs_i,
  input  logic                    ld_page_i,
  input  logic [OFS_W-1:0]        ofs_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic                    inc_i,
  output logic [OFS_W+PAGE_W-1:0] addr_o
);
  localparam int BA_W = OFS_W + PAGE_W;

  logic [BA_W-1:0] a_q, a_d;

  always_comb begin
    a_d = a_q;
    if (ld_ofs_i)  a_d[OFS_W-1:0]     = ofs_i;
    if (ld_page_i) a_d[BA_W-1:OFS_W] = page_i;
    if (inc_i)     a_d                = a_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_q <= '0;
    else        a_q <= a_d;
  end

  assign addr_o = a_q;
endmodule

// File: rtl/bdma_wait_timer.sv
module bdma_wait_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              last_o
);
  logic              first_q, first_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d, eff;

  assign eff    = first_q ? wait_i : cnt_q;
  assign last_o = active_i && (eff == '0);

  always_comb begin
    first_d = 1'b1;
    cnt_d   = cnt_q;
    if (active_i && !last_o) begin
      first_d = 1'b0;
      cnt_d   = eff - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      first_q <= first_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/bdma_packer.sv
module bdma_packer
  import bdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt_i,
  input  logic [1:0]        idx_i,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [WORD_W-1:0] w_q, w_d;
  logic [1:0]        lane;

  assign lane = (fmt_i == FMT_DM8HI) ? 2'd1 : (last_idx(fmt_i) - idx_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign w_d[g*BYTE_W +: BYTE_W] =
      load_i                          ? word_i[g*BYTE_W +: BYTE_W] :
      clr_i                           ? '0 :
      (cap_i && lane == 2'(g))        ? byte_i :
                                        w_q[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) w_q <= '0;
    else        w_q <= w_d;
  end

  always_comb begin
    case (lane)
      2'd2:    byte_o = w_q[3*BYTE_W-1:2*BYTE_W];
      2'd1:    byte_o = w_q[2*BYTE_W-1:BYTE_W];
      default: byte_o = w_q[BYTE_W-1:0];
    endcase
  end

  assign word_o = w_q;
endmodule

// File: rtl/bdma_engine.sv
module bdma_engine
  import bdma_pkg::*;
#(
  parameter int OFS_W   = 14,
  parameter int PAGE_W  = 8,
  parameter int CNT_W   = 14,
  parameter int IADDR_W = 14,
  parameter int WAIT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_sel,
  input  logic [15:0]             cfg_wdata,
  output logic [CNT_W-1:0]        cnt_o,
  output logic                    busy_o,
  output logic                    halt_o,
  output logic                    irq_o,
  output logic                    im_req_o,
  output logic                    im_we_o,
  output logic                    im_space_o,
  output logic [IADDR_W-1:0]      im_addr_o,
  output logic [23:0]             im_wdata_o,
  input  logic [23:0]             im_rdata_i,
  output logic                    bm_rd_o,
  output logic                    bm_wr_o,
  output logic [OFS_W+PAGE_W-1:0] bm_addr_o,
  output logic [7:0]              bm_wdata_o,
  input  logic [7:0]              bm_rdata_i,
  input  logic [WAIT_W-1:0]       bm_wait_i
);
  st_e                st_q, st_d;
  fmt_e               fmt_q, fmt_d;
  logic               dir_q, dir_d, halt_q, halt_d, irq_q, irq_d;
  logic [IADDR_W-1:0] ia_q, ia_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [1:0]         idx_q, idx_d;

  logic idle, acc_we, start, in_byte, byte_last, last_byte, word_done, cnt_one;
  logic unused_cfg;

  assign unused_cfg = ^cfg_wdata;
  assign idle      = (st_q == ST_IDLE);
  assign acc_we    = cfg_we && idle;
  assign start     = acc_we && (cfg_sel == SEL_COUNT) && (cfg_wdata[CNT_W-1:0] != '0);
  assign in_byte   = (st_q == ST_BYTE);
  assign last_byte = (idx_q == last_idx(fmt_q));
  assign word_done = (st_q == ST_IMWR) || (in_byte && byte_last && last_byte && dir_q);
  assign cnt_one   = (cnt_q == CNT_W'(1));

  // next-state logic
  always_comb begin
    st_d   = st_q;
    fmt_d  = fmt_q;
    dir_d  = dir_q;
    halt_d = halt_q;
    ia_d   = ia_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    irq_d  = 1'b0;

    if (acc_we) begin
      case (cfg_sel)
        SEL_CTRL: begin
          halt_d = cfg_wdata[3];
          dir_d  = cfg_wdata[2];
          fmt_d  = fmt_e'(cfg_wdata[1:0]);
        end
        SEL_IADDR: ia_d  = cfg_wdata[IADDR_W-1:0];
        SEL_COUNT: cnt_d = cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end

    case (st_q)
      ST_IDLE: if (start) begin
        st_d  = dir_q ? ST_FETCH : ST_BYTE;
        idx_d = 2'd0;
      end
      ST_BYTE: if (byte_last) begin
        if (last_byte) begin
          idx_d = 2'd0;
          if (!dir_q)       st_d = ST_IMWR;
          else if (cnt_one) st_d = ST_IDLE;
          else              st_d = ST_FETCH;
        end else begin
          idx_d = idx_q + 2'd1;
        end
      end
      ST_IMWR:  st_d = cnt_one ? ST_IDLE : ST_BYTE;
      ST_FETCH: st_d = ST_CAPT;
      ST_CAPT:  st_d = ST_BYTE;
      default:  st_d = ST_IDLE;
    endcase

    if (word_done) begin
      cnt_d = cnt_q - 1'b1;
      ia_d  = ia_q + 1'b1;
      irq_d = cnt_one;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fmt_q  <= FMT_PM24;
      dir_q  <= 1'b0;
      halt_q <= 1'b0;
      ia_q   <= '0;
      cnt_q  <= '0;
      idx_q  <= 2'd0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      fmt_q  <= fmt_d;
      dir_q  <= dir_d;
      halt_q <= halt_d;
      ia_q   <= ia_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      irq_q  <= irq_d;
    end
  end

  bdma_addr_ctr #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_ofs_i  (acc_we && (cfg_sel == SEL_OFS)),
    .ld_page_i (acc_we && (cfg_sel == SEL_PAGE)),
    .ofs_i     (cfg_wdata[OFS_W-1:0]),
    .page_i    (cfg_wdata[PAGE_W-1:0]),
    .inc_i     (in_byte && byte_last),
    .addr_o    (bm_addr_o)
  );

  bdma_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (in_byte),
    .wait_i   (bm_wait_i),
    .last_o   (byte_last)
  );

  bdma_packer u_pack (
    .clk    (clk),
    .rst_n  (rst_n),
    .fmt_i  (fmt_q),
    .idx_i  (idx_q),
    .clr_i  (start || (st_q == ST_IMWR)),
    .cap_i  (in_byte && byte_last && !dir_q),
    .byte_i (bm_rdata_i),
    .load_i (st_q == ST_CAPT),
    .word_i (im_rdata_i),
    .word_o (im_wdata_o),
    .byte_o (bm_wdata_o)
  );

  assign cnt_o      = cnt_q;
  assign busy_o     = !idle;
  assign halt_o     = !idle && halt_q;
  assign irq_o      = irq_q;
  assign im_req_o   = (st_q == ST_IMWR) || (st_q == ST_FETCH);
  assign im_we_o    = (st_q == ST_IMWR);
  assign im_space_o = (fmt_q != FMT_PM24);
  assign im_addr_o  = ia_q;
  assign bm_rd_o    = in_byte && !dir_q;
  assign bm_wr_o    = in_byte && dir_q;
endmodule

// File: rtl/bdma_engine_chk.sv
module bdma_engine_chk #(
  parameter int CNT_W = 14,
  parameter int BA_W  = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             halt_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             bm_rd_o,
  input logic             bm_wr_o,
  input logic [BA_W-1:0]  bm_addr_o,
  input logic             im_req_o
);
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_irq_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cnt_o == '0 && !busy_o));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bm_rd_o && bm_wr_o));

  assert_activity_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_rd_o || bm_wr_o || im_req_o) |-> busy_o);

  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    im_req_o |=> !im_req_o);

  assert_req_no_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    im_req_o |-> !(bm_rd_o || bm_wr_o));

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) - 1'b1));

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !(bm_rd_o || bm_wr_o)) |=> $stable(bm_addr_o));

  assert_halt_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> busy_o);
endmodule

bind bdma_engine bdma_engine_chk #(.CNT_W(CNT_W), .BA_W(OFS_W + PAGE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .halt_o    (halt_o),
  .irq_o     (irq_o),
  .cnt_o     (cnt_o),
  .bm_rd_o   (bm_rd_o),
  .bm_wr_o   (bm_wr_o),
  .bm_addr_o (bm_addr_o),
  .im_req_o  (im_req_o)
);

// File: tb/bdma_engine_bench.sv
module bdma_engine_bench;
  localparam int OFS_W = 14, PAGE_W = 8, CNT_W = 14, IADDR_W = 14, WAIT_W = 4;
  localparam int BA_W = OFS_W + PAGE_W;

  logic clk, rst_n, cfg_we;
  logic [2:0] cfg_sel;
  logic [15:0] cfg_wdata;
  logic [CNT_W-1:0] cnt;
  logic busy, halt, irq, im_req, im_we, im_space, bm_rd, bm_wr;
  logic [IADDR_W-1:0] im_addr;
  logic [23:0] im_wdata, im_rdata;
  logic [BA_W-1:0] bm_addr;
  logic [7:0] bm_wdata, bm_rdata;
  logic [WAIT_W-1:0] bm_wait;

  int errs, checks;

  // expected outputs of the reference model for the current cycle
  logic e_busy, e_halt, e_irq, e_rd, e_wr, e_req, e_we, e_space, e_8bit;
  int unsigned e_cnt;
  logic [BA_W-1:0] e_addr;
  logic [7:0] e_wbyte;
  logic [IADDR_W-1:0] e_ia;
  logic [23:0] e_word;
  string ctx;

  // model state
  logic [BA_W-1:0] m_addr;
  logic [IADDR_W-1:0] m_ia;
  int m_cnt;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  bdma_engine u_bdma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cnt_o(cnt), .busy_o(busy), .halt_o(halt), .irq_o(irq),
    .im_req_o(im_req), .im_we_o(im_we), .im_space_o(im_space), .im_addr_o(im_addr),
    .im_wdata_o(im_wdata), .im_rdata_i(im_rdata),
    .bm_rd_o(bm_rd), .bm_wr_o(bm_wr), .bm_addr_o(bm_addr), .bm_wdata_o(bm_wdata),
    .bm_rdata_i(bm_rdata), .bm_wait_i(bm_wait)
  );

  function automatic logic [7:0] bpat(logic [BA_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  function automatic logic [23:0] wpat(logic [IADDR_W-1:0] a);
    return {a[7:0] ^ 8'hC3, 2'b01, a[13:8], ~a[7:0]};
  endfunction

  // external byte memory and internal memory models
  assign bm_rdata = bpat(bm_addr);
  always @(posedge clk) im_rdata <= wpat(im_addr);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, ctx, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R4 busy",   32'(busy),   32'(e_busy));
    chk("R10 halt",  32'(halt),   32'(e_halt));
    chk("R5 count",  32'(cnt),    e_cnt);
    chk("R6 irq",    32'(irq),    32'(e_irq));
    chk("R9 read strobe",  32'(bm_rd), 32'(e_rd));
    chk("R9 write strobe", 32'(bm_wr), 32'(e_wr));
    chk("R8 request", 32'(im_req), 32'(e_req));
    if (e_rd || e_wr) chk("R3 address", 32'(bm_addr), 32'(e_addr));
    if (e_wr) chk(e_8bit ? "R2 byte out" : "R1 byte out", 32'(bm_wdata), 32'(e_wbyte));
    if (e_req) begin
      chk("R7 write enable", 32'(im_we), 32'(e_we));
      chk("R12 internal address", 32'(im_addr), 32'(e_ia));
      chk("R12 space", 32'(im_space), 32'(e_space));
    end
    if (e_req && e_we)
      chk(e_8bit ? "R2 packed word" : "R1 packed word", 32'(im_wdata), 32'(e_word));
    cfg_we = 1'b0;
  endtask

  task automatic wreg(int s, int d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = 3'(s);
    cfg_wdata = 16'(d);
  endtask

  task automatic set_idle();
    e_busy = 0; e_halt = 0; e_irq = 0; e_rd = 0; e_wr = 0; e_req = 0; e_we = 0;
  endtask

  // R11: writes issued while busy; the model ignores them
  task automatic poke(inout int pk);
    case (pk)
      0: begin cfg_we = 1'b1; cfg_sel = 3'd3; cfg_wdata = 16'h00FF; end
      1: begin cfg_we = 1'b1; cfg_sel = 3'd2; cfg_wdata = 16'h0000; end
      2: begin cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 16'h0005; end
      3: begin cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 16'h0007; end
      default: ;
    endcase
    pk++;
  endtask

  task automatic run(int fmt, int dir, int hlt, int ia, int ofs, int page, int n, int wt,
                     bit regs, bit pk_en, string c);
    int nb, lane, pk;
    logic [23:0] word;
    ctx = c;
    pk = pk_en ? 0 : 99;
    e_8bit = (fmt >= 2);
    nb = (fmt == 0) ? 3 : (fmt == 1) ? 2 : 1;
    wreg(0, (hlt << 3) | (dir << 2) | fmt);
    if (regs) begin
      wreg(1, ia); wreg(2, ofs); wreg(3, page);
      m_addr = {8'(page), 14'(ofs)};
      m_ia = 14'(ia);
    end
    bm_wait = 4'(wt);
    wreg(4, n);
    m_cnt = n;
    set_idle();
    e_busy = 1; e_halt = 1'(hlt); e_space = (fmt != 0);
    for (int w = 0; w < n; w++) begin
      e_cnt = m_cnt;
      if (dir == 0) begin
        word = '0;
        for (int b = 0; b < nb; b++) begin
          lane = (fmt == 0) ? 2 - b : (fmt == 1) ? 1 - b : (fmt == 2) ? 1 : 0;
          for (int k = 0; k <= wt; k++) begin
            e_rd = 1; e_addr = m_addr;
            tick(); poke(pk);
          end
          word = word | (24'(bpat(m_addr)) << (lane * 8));
          m_addr = m_addr + 1'b1;
        end
        e_rd = 0; e_req = 1; e_we = 1; e_ia = m_ia; e_word = word;
        tick(); poke(pk);
        e_req = 0; e_we = 0;
      end else begin
        e_req = 1; e_we = 0; e_ia = m_ia;
        tick(); poke(pk);
        e_req = 0;
        tick(); poke(pk);
        word = wpat(m_ia);
        for (int b = 0; b < nb; b++) begin
          lane = (fmt == 0) ? 2 - b : (fmt == 1) ? 1 - b : (fmt == 2) ? 1 : 0;
          for (int k = 0; k <= wt; k++) begin
            e_wr = 1; e_addr = m_addr; e_wbyte = word[lane*8 +: 8];
            tick(); poke(pk);
          end
          m_addr = m_addr + 1'b1;
        end
        e_wr = 0;
      end
      m_ia = m_ia + 1'b1;
      m_cnt--;
    end
    set_idle();
    e_irq = 1; e_cnt = 0;
    tick();
    e_irq = 0;
    tick();
  endtask

  task automatic finish_sim();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog [%s] actual=running expected=done", ctx);
    finish_sim();
  end

  initial begin
    errs = 0; checks = 0;
    cfg_we = 0; cfg_sel = '0; cfg_wdata = '0; bm_wait = '0; rst_n = 0;
    m_addr = '0; m_ia = '0; m_cnt = 0;
    set_idle(); e_cnt = 0; e_8bit = 0; ctx = "reset";
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 R3: 24-bit load crossing from page 5 into page 6
    run(0, 0, 0, 16'h0010, 16'h3FFE, 5, 3, 0, 1, 0, "R1 load 24-bit page cross");
    // R1 R9: 16-bit load with two wait cycles, halt set (R10)
    run(1, 0, 1, 16'h0100, 16'h0123, 7, 2, 2, 1, 0, "R1 load 16-bit wait 2");
    // R2 R11: high-lane byte load with writes poked while busy
    run(2, 0, 0, 16'h0200, 16'h1000, 2, 3, 1, 1, 1, "R11 load 8-bit high, busy writes");
    // R11: count-only restart continues address and internal address
    run(3, 0, 0, 0, 0, 0, 2, 0, 0, 0, "R11 continue, 8-bit low");
    // R7 R8: stores
    run(0, 1, 1, 16'h0300, 16'h0040, 1, 2, 1, 1, 0, "R7 store 24-bit");
    run(1, 1, 0, 16'h3FFF, 16'h0050, 1, 2, 0, 1, 1, "R7 store 16-bit, busy writes");
    run(2, 1, 0, 16'h0400, 16'h0060, 1, 1, 3, 1, 0, "R2 store 8-bit high");
    run(3, 1, 0, 16'h0401, 16'h0070, 1, 1, 0, 1, 0, "R2 store 8-bit low");
    // R3: wrap from the top of the byte space to zero
    run(1, 0, 0, 16'h0500, 16'h3FFF, 255, 1, 0, 1, 0, "R3 address wrap");
    run(1, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R3 continue after wrap");
    // R4: a zero count starts nothing
    ctx = "R4 zero count";
    wreg(4, 0);
    set_idle(); e_cnt = 0;
    tick(); tick(); tick();
    finish_sim();
  end
endmodule